// File: doc/BRIEF.md
# Burst-Capable SPI Master with Inter-Word Suspend

This block is the serial engine of an SPI controller. A one-cycle start pulse runs a transfer of one or two words. Each word is 1 to 32 bits long, shifted MSB-first or LSB-first. The serial clock has a selectable idle level and is made from the system clock by a programmable divider. Outgoing data changes on the leading edge of the serial clock, and incoming data is sampled on the trailing edge.

When a two-word burst is selected, the line is held quiet for a programmable suspend interval between the two words. The select line stays low across that interval. A completion flag is raised at the end of each transfer and is cleared by a clear pulse. The interrupt output is the flag gated by an enable. Configuration is presented as plain input fields and is expected to be stable while a transfer runs.

Top module: `spi_gap_master`

## Requirements
- R1: After reset, ss_n is 1, busy, flag, irq and mosi are 0, sclk equals cfg_cpol, and rx0 and rx1 read 0.
- R2: A start pulse while idle and cfg_slave is 0 drives ss_n low and busy high on the next clock. The first leading edge follows one SPI half period later, and each half period lasts cfg_div+1 system clocks. ss_n and busy return high/low one half period after the last trailing edge, so a single word keeps busy high for (2L+1)(cfg_div+1) clocks and a burst keeps it high for (4L+2*cfg_gap+4)(cfg_div+1) clocks, where L is the word length.
- R3: Whenever no bit is in its active phase, sclk rests at cfg_cpol (1 = idle high, 0 = idle low). The leading edge moves away from that level.
- R4: mosi changes only on leading edges, and miso is sampled on trailing edges.
- R5: cfg_len = 0 selects 32 bits per word, and cfg_len = n (1..31) selects n bits. Each word produces exactly that many trailing edges.
- R6: With cfg_lsb = 0, bit L-1 of the transmit word goes out first and the first received bit is stored at bit L-1. With cfg_lsb = 1, bit 0 goes out first and the first received bit is stored at bit 0. Receive bits at positions L and above read 0.
- R7: cfg_wcnt = 1 runs two words: the first uses tx0/rx0 and the second uses tx1/rx1. cfg_wcnt = 0, 2 or 3 runs one word with tx0/rx0, and rx1 keeps its value.
- R8: In a burst, the time from the last trailing edge of the first word to the first leading edge of the second word is (cfg_gap+2) SPI periods, which is 2*(cfg_gap+2)*(cfg_div+1) system clocks. ss_n stays low throughout.
- R9: In a single-word transfer, cfg_gap has no effect on the timing.
- R10: flag is set when a transfer completes and cleared by an irq_clr pulse. irq equals flag AND cfg_ie.
- R11: While cfg_slave is 1, a start pulse is ignored: busy stays 0, ss_n stays 1 and sclk stays idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst_n | input | 1 | active-low asynchronous reset |
| cfg_slave | input | 1 | 1 = slave selected, master engine held off |
| cfg_ie | input | 1 | interrupt enable |
| cfg_cpol | input | 1 | serial clock idle level |
| cfg_lsb | input | 1 | 1 = LSB first |
| cfg_wcnt | input | 2 | words per transfer (1 = two words) |
| cfg_len | input | $clog2(WORD_W) | bits per word, 0 = WORD_W |
| cfg_gap | input | GAP_W | suspend interval code |
| cfg_div | input | DIV_W | half period minus one, in system clocks |
| start | input | 1 | one-cycle transfer start |
| irq_clr | input | 1 | clears the completion flag |
| tx0 | input | WORD_W | first transmit word |
| tx1 | input | WORD_W | second transmit word |
| rx0 | output | WORD_W | first receive word |
| rx1 | output | WORD_W | second receive word |
| busy | output | 1 | transfer in progress |
| flag | output | 1 | transfer-complete flag |
| irq | output | 1 | gated interrupt |
| sclk | output | 1 | serial clock |
| mosi | output | 1 | serial data out |
| miso | input | 1 | serial data in |
| ss_n | output | 1 | active-low slave select |

## Verification
A bench-side slave model records mosi at every trailing edge and drives miso from a known pattern on every leading edge. The transfers vary the idle level, bit order, word count (including both reserved codes), length (1, 5, 8, 12, 31, 32), divider and gap. Pairing LSB-first with MSB-first words shows bit-order or index faults that a loopback would hide. Bursts at gap codes 0, 3 and 15 separate a wrong gap formula from a wrong divider, and single words with large gap codes show whether the suspend leaks into unburst timing. The 32-bit and 1-bit lengths cover the encoding wrap of the length field.

// File: rtl/spi_gap_pkg.sv
package spi_gap_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LEAD = 2'd1,
        ST_ACT  = 2'd2,
        ST_TAIL = 2'd3
    } spi_st_e;
endpackage

// File: rtl/spi_gap_timer.sv
module spi_gap_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] val_i,
    output logic         zero_o
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)
            cnt_d = val_i;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero_o = (cnt_q == '0);

    AST_TMR_STAYS_EXPIRED: assert property (@(posedge clk) disable iff (!rst_n)
        (zero_o && !load_i) |=> zero_o); // R8
endmodule

// File: rtl/spi_gap_bitsel.sv
module spi_gap_bitsel #(
    parameter int WORD_W = 32
) (
    input  logic [$clog2(WORD_W)-1:0] len_i,
    input  logic [$clog2(WORD_W):0]   k_i,
    input  logic                      lsb_i,
    output logic [$clog2(WORD_W)-1:0] idx_o,
    output logic                      last_o,
    output logic [$clog2(WORD_W):0]   nbits_o
);
    localparam int LEN_W = $clog2(WORD_W);
    localparam int CNT_W = LEN_W + 1;

    logic [CNT_W-1:0] msb_pos;

    always_comb begin
        nbits_o = (len_i == '0) ? CNT_W'(WORD_W) : {1'b0, len_i};
        msb_pos = nbits_o - 1'b1 - k_i;
        idx_o   = lsb_i ? k_i[LEN_W-1:0] : msb_pos[LEN_W-1:0];
        last_o  = (k_i == nbits_o - 1'b1);
    end
endmodule

// File: rtl/spi_gap_master.sv
module spi_gap_master
    import spi_gap_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int DIV_W  = 8,
    parameter int GAP_W  = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cfg_slave,
    input  logic                      cfg_ie,
    input  logic                      cfg_cpol,
    input  logic                      cfg_lsb,
    input  logic [1:0]                cfg_wcnt,
    input  logic [$clog2(WORD_W)-1:0] cfg_len,
    input  logic [GAP_W-1:0]          cfg_gap,
    input  logic [DIV_W-1:0]          cfg_div,
    input  logic                      start,
    input  logic                      irq_clr,
    input  logic [WORD_W-1:0]         tx0,
    input  logic [WORD_W-1:0]         tx1,
    output logic [WORD_W-1:0]         rx0,
    output logic [WORD_W-1:0]         rx1,
    output logic                      busy,
    output logic                      flag,
    output logic                      irq,
    output logic                      sclk,
    output logic                      mosi,
    input  logic                      miso,
    output logic                      ss_n
);
    localparam int LEN_W = $clog2(WORD_W);
    localparam int CNT_W = LEN_W + 1;
    localparam int TMR_W = DIV_W + GAP_W + 3;

    typedef struct packed {
        spi_st_e          st;
        logic             word;
        logic [CNT_W-1:0] bitk;
        logic             phase;
        logic             ss_n;
        logic             mosi;
        logic             flag;
        logic [WORD_W-1:0] rx0;
        logic [WORD_W-1:0] rx1;
    } regs_t;

    localparam regs_t RST = '{st: ST_IDLE, word: 1'b0, bitk: '0, phase: 1'b0,
                              ss_n: 1'b1, mosi: 1'b0, flag: 1'b0, rx0: '0, rx1: '0};

    regs_t d, q;

    logic             tmr_ld, tmr_zero, last_bit, burst;
    logic [TMR_W-1:0] tmr_val, gap_m1;
    logic [LEN_W-1:0] idx;
    logic [CNT_W-1:0] nbits;
    logic [WORD_W-1:0] txw;

    spi_gap_timer #(.W(TMR_W)) tmr_i (
        .clk(clk), .rst_n(rst_n), .load_i(tmr_ld), .val_i(tmr_val), .zero_o(tmr_zero)
    );

    spi_gap_bitsel #(.WORD_W(WORD_W)) sel_i (
        .len_i(cfg_len), .k_i(q.bitk), .lsb_i(cfg_lsb),
        .idx_o(idx), .last_o(last_bit), .nbits_o(nbits)
    );

    assign gap_m1 = (((TMR_W'(cfg_gap) + TMR_W'(2)) * (TMR_W'(cfg_div) + TMR_W'(1))) << 1)
                    - TMR_W'(1);

    always_comb begin
        d       = q;
        tmr_ld  = 1'b0;
        tmr_val = TMR_W'(cfg_div);
        burst   = (cfg_wcnt == 2'b01);
        txw     = q.word ? tx1 : tx0;
        if (irq_clr) d.flag = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (start && !cfg_slave) begin
                    d.st    = ST_LEAD;
                    d.ss_n  = 1'b0;
                    d.word  = 1'b0;
                    d.bitk  = '0;
                    d.phase = 1'b0;
                    tmr_ld  = 1'b1;
                end
            end
            ST_LEAD: begin
                if (tmr_zero) begin
                    d.phase = 1'b1;
                    d.mosi  = txw[idx];
                    if (q.bitk == '0) begin
                        if (q.word) d.rx1 = '0;
                        else        d.rx0 = '0;
                    end
                    d.st   = ST_ACT;
                    tmr_ld = 1'b1;
                end
            end
            ST_ACT: begin
                if (tmr_zero) begin
                    d.phase = 1'b0;
                    if (q.word) d.rx1[idx] = miso;
                    else        d.rx0[idx] = miso;
                    tmr_ld = 1'b1;
                    if (last_bit) begin
                        if (!q.word && burst) begin
                            d.st    = ST_LEAD;
                            d.word  = 1'b1;
                            d.bitk  = '0;
                            tmr_val = gap_m1;
                        end else begin
                            d.st = ST_TAIL;
                        end
                    end else begin
                        d.bitk = q.bitk + 1'b1;
                        d.st   = ST_LEAD;
                    end
                end
            end
            ST_TAIL: begin
                if (tmr_zero) begin
                    d.st   = ST_IDLE;
                    d.ss_n = 1'b1;
                    d.mosi = 1'b0;
                    d.flag = 1'b1;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= RST;
        else        q <= d;
    end

    assign rx0  = q.rx0;
    assign rx1  = q.rx1;
    assign busy = (q.st != ST_IDLE);
    assign flag = q.flag;
    assign irq  = q.flag & cfg_ie;
    assign sclk = cfg_cpol ^ q.phase;
    assign mosi = q.mosi;
    assign ss_n = q.ss_n;

    AST_SS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !ss_n); // R2
    AST_START_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !cfg_slave && !busy) |=> (busy && !ss_n)); // R2
    AST_SLAVE_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_slave && !busy) |=> !busy); // R11
    AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st != ST_ACT) |-> (sclk == cfg_cpol)); // R3
    AST_BIT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (q.bitk < nbits)); // R5
    AST_WORD1_BURST: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && q.word) |-> (cfg_wcnt == 2'b01)); // R7
    AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_clr && !(q.st == ST_TAIL && tmr_zero)) |=> !flag); // R10
endmodule

// File: tb/spi_gap_master_tb.sv
`timescale 1ns/1ps
module spi_gap_master_tb_top;
    typedef struct packed {
        logic        cpol;
        logic        lsb;
        logic        ie;
        logic [1:0]  wcnt;
        logic [4:0]  len;
        logic [3:0]  gap;
        logic [7:0]  div;
        logic [31:0] tx0;
        logic [31:0] tx1;
        logic [63:0] sb;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b0, 1'b1, 2'd0, 5'd8,  4'd0,  8'd0, 32'h0000_00A5, 32'h0,          64'h5A},
        '{1'b1, 1'b1, 1'b1, 2'd1, 5'd8,  4'd3,  8'd1, 32'h0000_003C, 32'h0000_00C3, 64'hB4E1},
        '{1'b0, 1'b0, 1'b0, 2'd1, 5'd0,  4'd0,  8'd0, 32'hDEAD_BEEF, 32'h1234_5678, 64'h0F1E2D3C_4B5A6978},
        '{1'b1, 1'b0, 1'b1, 2'd1, 5'd5,  4'd15, 8'd2, 32'h0000_0013, 32'h0000_000C, 64'h2B7},
        '{1'b0, 1'b1, 1'b1, 2'd0, 5'd31, 4'd7,  8'd1, 32'h7FFF_0001, 32'h0,          64'h6DB6DB6D},
        '{1'b0, 1'b0, 1'b1, 2'd2, 5'd12, 4'd2,  8'd0, 32'h0000_0ABC, 32'h0000_0FFF, 64'h965},
        '{1'b1, 1'b1, 1'b0, 2'd3, 5'd1,  4'd9,  8'd3, 32'h0000_0001, 32'h0,          64'h1},
        '{1'b0, 1'b0, 1'b1, 2'd0, 5'd8,  4'd15, 8'd0, 32'h0000_00A5, 32'h0,          64'hC3}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic cfg_slave = 1'b0, cfg_ie = 1'b0, cfg_cpol = 1'b0, cfg_lsb = 1'b0;
    logic [1:0]  cfg_wcnt = '0;
    logic [4:0]  cfg_len = '0;
    logic [3:0]  cfg_gap = '0;
    logic [7:0]  cfg_div = '0;
    logic start = 1'b0, irq_clr = 1'b0;
    logic [31:0] tx0 = '0, tx1 = '0;
    logic [31:0] rx0, rx1;
    logic busy, flag, irq, sclk, mosi, ss_n;
    logic miso = 1'b0;

    int errors = 0, checks = 0;
    logic mon_rst = 1'b1;
    logic [63:0] cur_sb = '0;
    logic [63:0] cap;
    int lead_t [64];
    int trail_t [64];
    int lead_n = 0, trail_n = 0, cyc = 0;
    logic prev_sclk = 1'b0;
    logic [31:0] exp_rx1 = '0;

    spi_gap_master #(.WORD_W(32), .DIV_W(8), .GAP_W(4)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_slave(cfg_slave), .cfg_ie(cfg_ie),
        .cfg_cpol(cfg_cpol), .cfg_lsb(cfg_lsb), .cfg_wcnt(cfg_wcnt), .cfg_len(cfg_len),
        .cfg_gap(cfg_gap), .cfg_div(cfg_div), .start(start), .irq_clr(irq_clr),
        .tx0(tx0), .tx1(tx1), .rx0(rx0), .rx1(rx1), .busy(busy), .flag(flag),
        .irq(irq), .sclk(sclk), .mosi(mosi), .miso(miso), .ss_n(ss_n)
    );

    always #2 clk = ~clk;

    // slave model: drives miso on leading edges, records mosi on trailing edges
    always @(negedge clk) begin
        cyc = cyc + 1;
        if (mon_rst) begin
            lead_n = 0;
            trail_n = 0;
            prev_sclk = sclk;
        end else if (sclk !== prev_sclk) begin
            if (sclk !== cfg_cpol) begin
                if (lead_n < 64) begin
                    lead_t[lead_n] = cyc;
                    miso = cur_sb[lead_n];
                end
                lead_n = lead_n + 1;
            end else begin
                if (trail_n < 64) begin
                    cap[trail_n] = mosi;
                    trail_t[trail_n] = cyc;
                end
                trail_n = trail_n + 1;
            end
            prev_sclk = sclk;
        end
    end

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    function automatic logic [63:0] place(input logic [63:0] bits, input int base,
                                          input int nb, input logic lsb);
        logic [63:0] r = '0;
        for (int k = 0; k < nb; k++) r[lsb ? k : nb - 1 - k] = bits[base + k];
        return r;
    endfunction

    task automatic run_vec(input vec_t v);
        int nb, h, n, exp_busy;
        logic brst;
        logic [63:0] mask;
        nb   = (v.len == 0) ? 32 : int'(v.len);
        h    = int'(v.div) + 1;
        brst = (v.wcnt == 2'd1);
        mask = (nb == 32) ? 64'hFFFF_FFFF : ((64'd1 << nb) - 1);
        @(posedge clk); #1;
        cfg_cpol = v.cpol; cfg_lsb = v.lsb; cfg_ie = v.ie; cfg_wcnt = v.wcnt;
        cfg_len = v.len; cfg_gap = v.gap; cfg_div = v.div; tx0 = v.tx0; tx1 = v.tx1;
        cur_sb = v.sb; mon_rst = 1'b1;
        repeat (2) @(posedge clk);
        #1 mon_rst = 1'b0;
        chk("R3 idle level", {63'd0, sclk}, {63'd0, v.cpol});
        start = 1'b1;
        @(posedge clk); #1 start = 1'b0;
        @(negedge clk);
        n = 0;
        while (busy === 1'b1) begin n++; @(negedge clk); end
        exp_busy = brst ? (4 * nb + 2 * int'(v.gap) + 4) * h : (2 * nb + 1) * h;
        if (brst) chk("R2 R8 busy length, burst", 64'(n), 64'(exp_busy));
        else      chk("R2 R9 busy length, single word", 64'(n), 64'(exp_busy));
        chk("R5 trailing edge count", 64'(trail_n), 64'(brst ? 2 * nb : nb));
        chk("R4 R6 mosi order word 0", place(cap, 0, nb, v.lsb), {32'd0, v.tx0} & mask);
        chk("R6 rx0 placement", {32'd0, rx0}, place(v.sb, 0, nb, v.lsb));
        if (nb > 1) begin
            chk("R2 R4 lead-to-trail half period", 64'(trail_t[0] - lead_t[0]), 64'(h));
            chk("R2 R4 trail-to-lead half period", 64'(lead_t[1] - trail_t[0]), 64'(h));
        end
        if (brst) begin
            chk("R8 suspend interval", 64'(lead_t[nb] - trail_t[nb - 1]),
                64'(2 * (int'(v.gap) + 2) * h));
            chk("R7 mosi order word 1", place(cap, nb, nb, v.lsb), {32'd0, v.tx1} & mask);
            exp_rx1 = place(v.sb, nb, nb, v.lsb);
        end
        chk("R7 rx1", {32'd0, rx1}, {32'd0, exp_rx1});
        chk("R10 flag and irq after completion", {62'd0, flag, irq}, {62'd0, 1'b1, v.ie});
        @(posedge clk); #1 irq_clr = 1'b1;
        @(posedge clk); #1 irq_clr = 1'b0;
        @(negedge clk);
        chk("R10 flag cleared", {62'd0, flag, irq}, 64'd0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset pins", {58'd0, ss_n, busy, flag, irq, mosi, sclk},
            {58'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0});
        chk("R1 reset rx", {rx1, rx0}, 64'd0);

        for (int i = 0; i < NV; i++) run_vec(VECS[i]);

        // R11: start ignored in slave mode
        @(posedge clk); #1 cfg_slave = 1'b1; cfg_cpol = 1'b1; start = 1'b1;
        @(posedge clk); #1 start = 1'b0;
        repeat (8) @(negedge clk);
        chk("R11 slave ignores start", {61'd0, busy, ss_n, sclk}, {61'd0, 1'b0, 1'b1, 1'b1});
        chk("R11 slave leaves rx", {rx1, rx0}, {exp_rx1, 32'(place(VECS[NV-1].sb, 0, 8, 1'b0))});
        @(posedge clk); #1 cfg_slave = 1'b0; cfg_cpol = 1'b0;
        @(negedge clk);
        chk("R3 idle low after polarity change", {63'd0, sclk}, 64'd0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired, actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule